// File: doc/BRIEF.md
# Accumulator Execute Unit with Condition Code

This block is the integer execute stage of a 24-bit single-accumulator machine. Each operation takes an operation code and a 24-bit memory operand, combines the operand with the accumulator, and writes the result back to the accumulator. The supported operations are load, add, subtract, multiply, divide and compare. All values are 24-bit two's complement integers.

Compare leaves the accumulator alone and instead records a three-way condition code: less, equal or greater, from a signed comparison. This code is the condition-code field of the status word. A jump evaluator reads that field and a jump-condition select, and reports whether a conditional branch would be taken. Load, add, subtract and compare finish in one cycle. Multiply and divide are iterative, with one step per operand bit. A start/busy/done handshake paces them, and starts that arrive while busy are dropped. Fetching the operand and decoding instructions are left to the surrounding pipeline.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `acc` is cleared to 0, `cc` becomes 2'b00 (equal), and `busy`, `done` and `div_err` are cleared.
- R2: A start with `op`=0 (load) puts `operand` into `acc` at the accepting edge.
- R3: Start with `op`=1 (add) or `op`=2 (subtract) gives `acc`+`operand` or `acc`-`operand` modulo 2^24 at the accepting edge, and `cc` does not change.
- R4: A start with `op`=5 (compare) compares `acc` against `operand` as signed values and sets `cc` to 2'b01 for less, 2'b00 for equal and 2'b10 for greater. `acc` is unchanged. No other operation alters `cc`.
- R5: `jmp_taken` depends on `cc` and `jmp_cond` through combinational logic only. Code 0 is taken on equal, 1 on less, 2 on greater, and 3 is always taken.
- R6: A start with `op`=3 (multiply) raises `busy` at the accepting edge. The low 24 bits of `acc`×`operand` are written to `acc` 25 edges later, and `done` rises at that same edge.
- R7: A start with `op`=4 (divide) follows the timing of R6. It writes the signed quotient `acc`/`operand`, truncated toward zero, to `acc`.
- R8: A divide by zero leaves `acc` unchanged and sets `div_err` at the completion edge. `div_err` clears when the next operation is accepted.
- R9: A start is accepted only when `busy` is low. A start while busy has no effect on `acc`, `cc` or the completion timing.
- R10: `done` is high for one cycle per accepted operation: the cycle after the accepting edge for single-cycle operations, and the cycle after the completion edge for multiply and divide. `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to execute `op` |
| op | input | 3 | Operation: 0 load, 1 add, 2 sub, 3 mul, 4 div, 5 compare |
| operand | input | 24 | Memory operand word |
| jmp_cond | input | 2 | Jump condition select (see R5) |
| acc | output | 24 | Accumulator register |
| cc | output | 2 | Condition-code field of the status word |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last divide had a zero divisor |
| jmp_taken | output | 1 | Selected jump condition holds |

## Verification
Load, add, subtract and compare update `acc` or `cc` at the same edge that accepts the start, and `done` is high in the cycle that follows. Multiply and divide complete exactly 25 edges after acceptance. `jmp_taken` follows `cc` and `jmp_cond` within the same cycle. The bench drives and samples on falling edges and counts falling edges from the accepting edge. It checks that `done` stays low through the first 24 of them, then checks `done`, `busy` and the result on the 25th. Changes to the jump select are checked a nanosecond later, with no clock edge in between.

// File: rtl/acc_exec_pkg.sv
// Package acc_exec_pkg
// Shared encodings for the accumulator execute unit: operation codes,
// condition-code values and jump-condition selects.
package acc_exec_pkg;
    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4,
        OP_CMP  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10
    } cc_e;

    typedef enum logic [1:0] {
        JC_EQ  = 2'd0,
        JC_LT  = 2'd1,
        JC_GT  = 2'd2,
        JC_ALL = 2'd3
    } jcond_e;
endpackage

// File: rtl/acc_mul_iter.sv
// Module acc_mul_iter
// Shift-and-add multiplier keeping the low W bits of the product.
// Assumes: start is a one-cycle pulse given only while idle. After start,
// runs W steps and pulses fin_o in the cycle after the last step.
module acc_mul_iter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         fin_o,
    output logic [W-1:0] prod_o
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic [W-1:0]     mcand_q;
    logic [W-1:0]     mplier_q;
    logic [W-1:0]     prod_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;

    // Load operands on start, then add and shift one multiplier bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
            cnt_q    <= '0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                mcand_q  <= mcand_i;
                mplier_q <= mplier_i;
                prod_q   <= '0;
                cnt_q    <= CNT_W'(W);
            end else if (cnt_q != '0) begin
                if (mplier_q[0]) prod_q <= prod_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - 1'b1;
                fin_q    <= (cnt_q == CNT_W'(1));
            end
        end
    end

    assign fin_o  = fin_q;
    assign prod_o = prod_q;

    // R6: the finish pulse never lasts two cycles
    a_r6_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);
    // R6: a finish pulse only follows the final step
    a_r6_fin_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_q) |-> (cnt_q == '0));
endmodule

// File: rtl/acc_div_iter.sv
// Module acc_div_iter
// Signed restoring divider, quotient truncated toward zero.
// Assumes: start is a one-cycle pulse given only while idle. Works on the
// magnitudes for W steps and fixes the sign of the quotient at the output.
// A zero divisor yields an unspecified quotient; the caller handles it.
module acc_div_iter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         fin_o,
    output logic [W-1:0] quot_o
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic [W-1:0]     dvd_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     rem_q;
    logic             neg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fin_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    // One restoring step: bring in the next dividend bit and try a subtract.
    always_comb begin
        shifted = {rem_q, dvd_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    // Capture magnitudes on start, then produce one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            neg_q <= 1'b0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                dvd_q <= dividend_i[W-1] ? -dividend_i : dividend_i;
                dvs_q <= divisor_i[W-1]  ? -divisor_i  : divisor_i;
                rem_q <= '0;
                neg_q <= dividend_i[W-1] ^ divisor_i[W-1];
                cnt_q <= CNT_W'(W);
            end else if (cnt_q != '0) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    dvd_q <= {dvd_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    dvd_q <= {dvd_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                fin_q <= (cnt_q == CNT_W'(1));
            end
        end
    end

    assign fin_o  = fin_q;
    assign quot_o = neg_q ? -dvd_q : dvd_q;

    // R7: the finish pulse never lasts two cycles
    a_r7_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |=> !fin_q);
    // R7: the partial remainder stays below the divisor once running
    a_r7_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && cnt_q != CNT_W'(W) && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/acc_cc_unit.sv
// Module acc_cc_unit
// Signed compare producing the three-way condition code, plus the jump
// evaluator that tests the stored code. Purely combinational.
module acc_cc_unit
    import acc_exec_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic [1:0]   cc_i,
    input  logic [1:0]   jcond_i,
    output logic [1:0]   cmp_cc_o,
    output logic         taken_o
);
    // Classify lhs against rhs as signed integers.
    always_comb begin
        if ($signed(lhs_i) < $signed(rhs_i))      cmp_cc_o = CC_LT;
        else if ($signed(lhs_i) > $signed(rhs_i)) cmp_cc_o = CC_GT;
        else                                      cmp_cc_o = CC_EQ;
    end

    // Decide whether the selected jump condition matches the stored code.
    always_comb begin
        unique case (jcond_e'(jcond_i))
            JC_EQ:   taken_o = (cc_i == CC_EQ);
            JC_LT:   taken_o = (cc_i == CC_LT);
            JC_GT:   taken_o = (cc_i == CC_GT);
            default: taken_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/acc_exec_unit.sv
// Module acc_exec_unit
// Accumulator execute unit: load/add/sub/compare finish in one cycle;
// multiply and divide use the iterative units and complete W+1 edges after
// acceptance. Assumes the operand is valid in the cycle start is high.
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] operand,
    input  logic [1:0]   jmp_cond,
    output logic [W-1:0] acc,
    output logic [1:0]   cc,
    output logic         busy,
    output logic         done,
    output logic         div_err,
    output logic         jmp_taken
);
    logic [W-1:0] acc_q;
    logic [1:0]   cc_q;
    logic         busy_q;
    logic         done_q;
    logic         err_q;
    logic         pend_div_q;
    logic         zero_dvs_q;
    logic         accept;
    op_e          op_v;
    logic         mul_go;
    logic         div_go;
    logic         mul_fin;
    logic         div_fin;
    logic [W-1:0] mul_res;
    logic [W-1:0] div_res;
    logic [1:0]   cmp_cc;

    assign accept = start && !busy_q;
    assign op_v   = op_e'(op);
    assign mul_go = accept && (op_v == OP_MUL);
    assign div_go = accept && (op_v == OP_DIV);

    acc_mul_iter #(.W(W)) mul_i (
        .clk(clk), .rst_n(rst_n), .start(mul_go),
        .mcand_i(acc_q), .mplier_i(operand),
        .fin_o(mul_fin), .prod_o(mul_res)
    );

    acc_div_iter #(.W(W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_go),
        .dividend_i(acc_q), .divisor_i(operand),
        .fin_o(div_fin), .quot_o(div_res)
    );

    acc_cc_unit #(.W(W)) cc_i (
        .lhs_i(acc_q), .rhs_i(operand),
        .cc_i(cc_q), .jcond_i(jmp_cond),
        .cmp_cc_o(cmp_cc), .taken_o(jmp_taken)
    );

    // Accept operations, retire single-cycle ones, and collect iterative results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cc_q       <= CC_EQ;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            pend_div_q <= 1'b0;
            zero_dvs_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                err_q <= 1'b0;
                unique case (op_v)
                    OP_LOAD: begin acc_q <= operand;         done_q <= 1'b1; end
                    OP_ADD:  begin acc_q <= acc_q + operand; done_q <= 1'b1; end
                    OP_SUB:  begin acc_q <= acc_q - operand; done_q <= 1'b1; end
                    OP_CMP:  begin cc_q  <= cmp_cc;          done_q <= 1'b1; end
                    OP_MUL:  begin busy_q <= 1'b1; pend_div_q <= 1'b0; end
                    OP_DIV:  begin
                        busy_q     <= 1'b1;
                        pend_div_q <= 1'b1;
                        zero_dvs_q <= (operand == '0);
                    end
                    default: done_q <= 1'b1;
                endcase
            end else if (busy_q && (mul_fin || div_fin)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                if (!pend_div_q)    acc_q <= mul_res;
                else if (zero_dvs_q) err_q <= 1'b1;
                else                acc_q <= div_res;
            end
        end
    end

    assign acc     = acc_q;
    assign cc      = cc_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign div_err = err_q;

    // R10: completion never overlaps a running operation
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R9: while an iterative unit is still working the accumulator holds
    a_r9_acc_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !mul_fin && !div_fin) |=> $stable(acc_q));
    // R4: only an accepted compare may change the condition code
    a_r4_cc_only_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && op_v == OP_CMP) |=> $stable(cc_q));
    // R4: the condition code is always one of the three legal values
    a_r4_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc_q));
    // R8: the error flag rises only at the end of a divide
    a_r8_err_from_div: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(busy_q && pend_div_q));
endmodule

// File: tb/acc_exec_unit_tb_top.sv
`timescale 1ns/1ps
module acc_exec_unit_tb_top;
    localparam int W = 24;
    localparam int LAT = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] operand = '0;
    logic [1:0]   jmp_cond = 2'd0;
    logic [W-1:0] acc;
    logic [1:0]   cc;
    logic         busy, done, div_err, jmp_taken;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    acc_exec_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .jmp_cond(jmp_cond), .acc(acc), .cc(cc), .busy(busy), .done(done),
        .div_err(div_err), .jmp_taken(jmp_taken)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b);
        int sa, sb;
        sa = int'($signed(a));
        sb = int'($signed(b));
        return W'(sa / sb);
    endfunction

    // Drive one start pulse; returns at the falling edge after the accepting edge.
    task automatic issue(input logic [2:0] o, input logic [W-1:0] d);
        @(negedge clk);
        start = 1'b1; op = o; operand = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic single(input string req, input logic [2:0] o, input logic [W-1:0] d,
                          input logic [W-1:0] exp_acc);
        issue(o, d);
        chk({req, " acc"}, acc, exp_acc);
        chk("R10 done after single-cycle op", W'(done), W'(1));
    endtask

    task automatic iterative(input string req, input logic [2:0] o, input logic [W-1:0] d,
                             input logic [W-1:0] exp_acc);
        bit early;
        early = 1'b0;
        issue(o, d);
        chk("R6 busy after accept", W'(busy), W'(1));
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (done) early = 1'b1;
        end
        chk("R10 no early done", W'(early), W'(0));
        @(negedge clk);
        chk("R10 done at completion", W'(done), W'(1));
        chk("R10 busy low at done", W'(busy), W'(0));
        chk({req, " result"}, acc, exp_acc);
    endtask

    task automatic t_reset();
        chk("R1 acc", acc, '0);
        chk("R1 cc", W'(cc), W'(0));
        chk("R1 busy", W'(busy), W'(0));
        chk("R1 done", W'(done), W'(0));
        chk("R1 div_err", W'(div_err), W'(0));
    endtask

    task automatic t_load();
        single("R2 load", 3'd0, 24'h123456, 24'h123456);
        @(negedge clk);
        chk("R10 done one cycle", W'(done), W'(0));
    endtask

    task automatic t_addsub();
        single("R2 load", 3'd0, 24'hFFFFFB, 24'hFFFFFB);
        single("R4 cmp setup", 3'd5, 24'h000003, 24'hFFFFFB);
        chk("R4 cc less", W'(cc), W'(2'b01));
        single("R3 add wrap", 3'd1, 24'h000008, 24'h000003);
        chk("R3 cc unchanged by add", W'(cc), W'(2'b01));
        single("R2 load", 3'd0, 24'h000000, 24'h000000);
        single("R3 sub wrap", 3'd2, 24'h000001, 24'hFFFFFF);
        chk("R3 cc unchanged by sub", W'(cc), W'(2'b01));
    endtask

    task automatic t_cmp_jump();
        single("R2 load", 3'd0, 24'h000007, 24'h000007);
        single("R4 cmp equal keeps acc", 3'd5, 24'h000007, 24'h000007);
        chk("R4 cc equal", W'(cc), W'(2'b00));
        jmp_cond = 2'd0; #1 chk("R5 jeq taken", W'(jmp_taken), W'(1));
        jmp_cond = 2'd1; #1 chk("R5 jlt not taken", W'(jmp_taken), W'(0));
        single("R2 load", 3'd0, 24'h7FFFFF, 24'h7FFFFF);
        single("R4 cmp signed greater", 3'd5, 24'h800000, 24'h7FFFFF);
        chk("R4 cc greater", W'(cc), W'(2'b10));
        jmp_cond = 2'd2; #1 chk("R5 jgt taken", W'(jmp_taken), W'(1));
        jmp_cond = 2'd0; #1 chk("R5 jeq not taken", W'(jmp_taken), W'(0));
        jmp_cond = 2'd3; #1 chk("R5 always taken", W'(jmp_taken), W'(1));
    endtask

    task automatic t_mul();
        single("R2 load", 3'd0, 24'd1234, 24'd1234);
        iterative("R6 mul", 3'd3, 24'd567, ref_mul(24'd1234, 24'd567));
        single("R2 load", 3'd0, 24'hFFFFFD, 24'hFFFFFD);
        iterative("R6 mul negative", 3'd3, 24'd5, ref_mul(24'hFFFFFD, 24'd5));
        single("R2 load", 3'd0, 24'h400000, 24'h400000);
        iterative("R6 mul overflow low bits", 3'd3, 24'd4, 24'h000000);
    endtask

    task automatic t_div();
        single("R2 load", 3'd0, 24'd100, 24'd100);
        iterative("R7 div", 3'd4, 24'd7, ref_div(24'd100, 24'd7));
        single("R2 load", 3'd0, -24'sd100, -24'sd100);
        iterative("R7 div neg dividend", 3'd4, 24'd7, ref_div(-24'sd100, 24'd7));
        single("R2 load", 3'd0, 24'd100, 24'd100);
        iterative("R7 div neg divisor", 3'd4, -24'sd7, ref_div(24'd100, -24'sd7));
        single("R2 load", 3'd0, -24'sd7, -24'sd7);
        iterative("R7 div small", 3'd4, -24'sd100, 24'd0);
    endtask

    task automatic t_divzero();
        single("R2 load", 3'd0, 24'd42, 24'd42);
        iterative("R8 div by zero keeps acc", 3'd4, 24'd0, 24'd42);
        chk("R8 div_err set", W'(div_err), W'(1));
        single("R2 load", 3'd0, 24'd9, 24'd9);
        chk("R8 div_err cleared", W'(div_err), W'(0));
    endtask

    task automatic t_busy_ignore();
        bit early;
        early = 1'b0;
        single("R2 load", 3'd0, 24'd6, 24'd6);
        issue(3'd3, 24'd7);
        start = 1'b1; op = 3'd0; operand = 24'hABCDEF;
        @(negedge clk);
        start = 1'b0;
        chk("R9 ignored load leaves acc", acc, 24'd6);
        for (int i = 2; i < LAT; i++) begin
            @(negedge clk);
            if (done) early = 1'b1;
        end
        chk("R9 no extra done", W'(early), W'(0));
        @(negedge clk);
        chk("R9 done timing kept", W'(done), W'(1));
        chk("R9 result not overwritten", acc, 24'd42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_addsub();
        t_cmp_jump();
        t_mul();
        t_div();
        t_divzero();
        t_busy_ignore();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule